// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM. A shared data bus can change between reads and writes on every clock with no idle cycle. Address, control and byte enables are registered on the rising clock edge. A read returns its word two enabled edges after the address is taken. A write takes its data from the bus two enabled edges after its address. That data waits in a pending-write register and is copied into the array when the next write reaches the same point. A read that hits the pending word gets those bytes straight from the register.

A command is started with the load strobe low. Holding the strobe high continues that command as a burst: a two-bit counter steps the two low address bits, in linear or interleaved order. The order is chosen by a select input that is sampled when the burst is loaded. A clock-enable input freezes the whole pipeline. Three chip enables, one active high and two active low, select the device.

Top module: `zt_sram`

## Requirements
- R1: Address, command, chip enables and byte enables are captured only at a rising clock edge where `clk_en_n` is low.
- R2: With `adv_ld` low, a new address and command are loaded (read when `we_n` is high, write when it is low). With `adv_ld` high, the previous command type and chip-select result continue, the address bits above bit 1 are kept, and the burst counter steps.
- R3: With `burst_ord` low at load, the k-th beat of a burst (k = 0..3, wrapping back to 0) uses low address bits (start + k) mod 4.
- R4: With `burst_ord` high at load, the k-th beat uses low address bits start XOR k.
- R5: Read data for a command taken at enabled edge E is on `dq_out` after enabled edge E+2 and stays there until the next read completes.
- R6: Write data is sampled from `dq_in` at enabled edge E+2 for a write taken at edge E. Lane i (bits 9i+8 down to 9i) is written only when `bw_n[i]` was low in the address cycle. Through the read at E+2, the bus is released from the edge after E+2.
- R7: A read of an address whose write data has been sampled but not yet copied into the array returns the pending bytes for the enabled lanes and the array bytes for the others.
- R8: A cycle is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A deselected cycle writes nothing, and the output stage holds no read two edges later.
- R9: While `clk_en_n` is high, all inputs except `oe_n` are ignored and all internal state and `dq_out` hold their values.
- R10: `dq_oe` is high only when `oe_n` is low and the output stage holds a selected read.
- R11: After reset, no command is in flight, no write is pending and `dq_oe` is low.
- R12: Reads and writes may alternate on every enabled cycle, also at the same address, with no idle cycle and no lost or stale data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| we_n | input | 1 | Low: write command, high: read |
| bw_n | input | LANES | Per-lane write enables, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | Low: load new command, high: advance burst |
| clk_en_n | input | 1 | High: suspend the clock |
| burst_ord | input | 1 | Low: linear burst, high: interleaved burst |
| oe_n | input | 1 | Output enable, active low |
| dq_in | input | DATA_W | Data bus, inbound side |
| dq_out | output | DATA_W | Data bus, outbound side |
| dq_oe | output | 1 | Drive enable for `dq_out` |

## Verification
The assertions check the following on every cycle:
- address capture on load;
- preservation of the upper address bits while a burst advances;
- the two-edge read latency into the output stage;
- release of the bus after write and deselect slots;
- freezing of state and output during clock suspension.

Data correctness cannot be shown by the properties. This covers the linear and interleaved beat order, byte-lane merging, forwarding from the pending write, and read/write alternation at one address. The bench's reference model shows these by comparing the output on every clock, in directed and random traffic.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic {
        BURST_LINEAR     = 1'b0,
        BURST_INTERLEAVE = 1'b1
    } burst_order_e;

    // Low two address bits for a beat, given the burst start and beat index.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input burst_order_e order);
        logic [1:0] res;
        case (order)
            BURST_INTERLEAVE: res = start ^ beat;
            default:          res = start + beat;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              load,
    input  logic              order_in,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [1:0]        cur_start,
    input  logic [1:0]        cur_beat,
    input  logic              cur_order,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [1:0]        nxt_start,
    output logic [1:0]        nxt_beat,
    output logic              nxt_order
);

    logic [1:0] beat_inc;

    always_comb begin
        beat_inc = cur_beat + 2'd1;
        if (load) begin
            nxt_addr  = ext_addr;
            nxt_start = ext_addr[1:0];
            nxt_beat  = 2'd0;
            nxt_order = order_in;
        end else begin
            nxt_start = cur_start;
            nxt_beat  = beat_inc;
            nxt_order = cur_order;
            nxt_addr  = {cur_addr[ADDR_W-1:2],
                         burst_low(cur_start, beat_inc, burst_order_e'(cur_order))};
        end
    end

endmodule

// File: rtl/zt_lane_merge.sv
module zt_lane_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              hit,
    input  logic [LANES-1:0]  pend_lanes,
    input  logic [DATA_W-1:0] pend_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] merged
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] = (hit && pend_lanes[i])
                                          ? pend_data[i*LANE_W +: LANE_W]
                                          : arr_data[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
    parameter int WORDS  = 16,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_lanes[i]) begin
                    mem_q[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adv_ld,
    input  logic              clk_en_n,
    input  logic              burst_ord,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
        logic [1:0]        start;
        logic [1:0]        beat;
        logic              order;
    } stage_t;

    typedef struct packed {
        stage_t            s1;     // command taken at the last enabled edge
        stage_t            s2;     // command one edge older
        logic              pvld;   // pending write present
        logic [ADDR_W-1:0] paddr;
        logic [LANES-1:0]  plns;
        logic [DATA_W-1:0] pdat;
        logic              ovld;   // output stage holds a selected read
        logic [DATA_W-1:0] odat;
    } state_t;

    state_t st_d, st_q;

    logic              sel_now;
    logic [ADDR_W-1:0] bg_addr;
    logic [1:0]        bg_start, bg_beat;
    logic              bg_order;
    logic [DATA_W-1:0] arr_rd, merged;
    logic              pend_hit;
    logic              arr_we;

    assign sel_now = !ce1_n && ce2 && !ce3_n;

    zt_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
        .load      (!adv_ld),
        .order_in  (burst_ord),
        .ext_addr  (addr),
        .cur_addr  (st_q.s1.addr),
        .cur_start (st_q.s1.start),
        .cur_beat  (st_q.s1.beat),
        .cur_order (st_q.s1.order),
        .nxt_addr  (bg_addr),
        .nxt_start (bg_start),
        .nxt_beat  (bg_beat),
        .nxt_order (bg_order)
    );

    // The pending word is copied into the array when the next write takes its data.
    assign arr_we = !clk_en_n && st_q.s2.vld && st_q.s2.wr && st_q.pvld;

    zt_sram_array #(.WORDS(WORDS), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .wr_en    (arr_we),
        .wr_addr  (st_q.paddr),
        .wr_lanes (st_q.plns),
        .wr_data  (st_q.pdat),
        .rd_addr  (st_q.s2.addr),
        .rd_data  (arr_rd)
    );

    assign pend_hit = st_q.pvld && (st_q.paddr == st_q.s2.addr);

    zt_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .hit        (pend_hit),
        .pend_lanes (st_q.plns),
        .pend_data  (st_q.pdat),
        .arr_data   (arr_rd),
        .merged     (merged)
    );

    always_comb begin
        st_d = st_q;
        if (!clk_en_n) begin
            st_d.s1.vld   = adv_ld ? st_q.s1.vld : sel_now;
            st_d.s1.wr    = adv_ld ? st_q.s1.wr  : !we_n;
            st_d.s1.addr  = bg_addr;
            st_d.s1.lanes = ~bw_n;
            st_d.s1.start = bg_start;
            st_d.s1.beat  = bg_beat;
            st_d.s1.order = bg_order;
            st_d.s2       = st_q.s1;
            if (st_q.s2.vld && st_q.s2.wr) begin
                st_d.pvld  = 1'b1;
                st_d.paddr = st_q.s2.addr;
                st_d.plns  = st_q.s2.lanes;
                st_d.pdat  = dq_in;
                st_d.ovld  = 1'b0;
            end else if (st_q.s2.vld) begin
                st_d.ovld  = 1'b1;
                st_d.odat  = merged;
            end else begin
                st_d.ovld  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out = st_q.odat;
    assign dq_oe  = st_q.ovld && !oe_n;

    // Observation points for the bound checker.
    logic              mon_s1_vld, mon_s2_vld, mon_s2_wr, mon_out_vld;
    logic [ADDR_W-1:0] mon_s1_addr;
    assign mon_s1_vld  = st_q.s1.vld;
    assign mon_s1_addr = st_q.s1.addr;
    assign mon_s2_vld  = st_q.s2.vld;
    assign mon_s2_wr   = st_q.s2.wr;
    assign mon_out_vld = st_q.ovld;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              adv_ld,
    input logic [ADDR_W-1:0] addr,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out,
    input logic              s1_vld,
    input logic [ADDR_W-1:0] s1_addr,
    input logic              s2_vld,
    input logic              s2_wr,
    input logic              out_vld
);

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld) |=> (s1_addr == $past(addr)));

    assert_burst_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld) |=>
            (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]) && s1_vld == $past(s1_vld)));

    assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && s2_vld && !s2_wr) |=> out_vld);

    assert_write_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && s2_vld && s2_wr) |=> !dq_oe);

    assert_deselect_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !s2_vld) |=> !out_vld);

    assert_suspend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(dq_out) && $stable(out_vld) && $stable(s1_addr) && $stable(s2_vld)));

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .addr     (addr),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out),
    .s1_vld   (mon_s1_vld),
    .s1_addr  (mon_s1_addr),
    .s2_vld   (mon_s2_vld),
    .s2_wr    (mon_s2_wr),
    .out_vld  (mon_out_vld)
);

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;

    localparam int WORDS = 16;
    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int DW    = LANES * LW;
    localparam int AW    = $clog2(WORDS);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we_n = 1'b1;
    logic [LANES-1:0] bw_n = '1;
    logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic          adv_ld = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          burst_ord = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    zt_sram #(.WORDS(WORDS), .LANES(LANES), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we_n(we_n), .bw_n(bw_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv_ld(adv_ld),
        .clk_en_n(clk_en_n), .burst_ord(burst_ord), .oe_n(oe_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // ---------------- behavioural reference ----------------
    typedef struct {
        bit v;
        bit w;
        int a;
        bit [LANES-1:0] ln;
    } mcmd_t;

    logic [DW-1:0] mem_m [WORDS];
    mcmd_t pq[$];
    bit sel_m, wr_m, ilv_m, ovld_m;
    int base_m, start_m, k_m;
    logic [DW-1:0] odat_m = '0;

    always @(posedge clk) begin
        mcmd_t c;
        mcmd_t e;
        if (!rst_n) begin
            pq.delete();
            ovld_m = 0; sel_m = 0; wr_m = 0; ilv_m = 0;
            base_m = 0; start_m = 0; k_m = 0;
        end else if (!clk_en_n) begin
            if (!adv_ld) begin
                sel_m   = (ce1_n == 0) && (ce2 == 1) && (ce3_n == 0);
                wr_m    = !we_n;
                base_m  = int'(addr);
                start_m = int'(addr) % 4;
                k_m     = 0;
                ilv_m   = burst_ord;
            end else begin
                k_m = (k_m + 1) % 4;
            end
            c.v  = sel_m;
            c.w  = wr_m;
            c.a  = (base_m / 4) * 4 + (ilv_m ? (start_m ^ k_m) : ((start_m + k_m) % 4));
            c.ln = ~bw_n;
            pq.push_back(c);
            if (pq.size() == 3) begin
                e = pq.pop_front();
                if (e.v && e.w) begin
                    for (int i = 0; i < LANES; i++)
                        if (e.ln[i]) mem_m[e.a][i*LW +: LW] = dq_in[i*LW +: LW];
                    ovld_m = 0;
                end else if (e.v) begin
                    odat_m = mem_m[e.a];
                    ovld_m = 1;
                end else begin
                    ovld_m = 0;
                end
            end else begin
                ovld_m = 0;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;
    string cur_req = "R11";
    bit done = 0;

    task automatic chk(input bit ok, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit exp_oe;
        exp_oe = ovld_m && !oe_n;
        chk(dq_oe === exp_oe, "dq_oe", DW'(dq_oe), DW'(exp_oe));
        if (ovld_m && !$isunknown(odat_m))
            chk(dq_out === odat_m, "dq_out", dq_out, odat_m);
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
        dq_in = rnd_word();
    endtask

    task automatic cmd(input bit load, input bit wr, input int a, input bit [LANES-1:0] bwn);
        adv_ld = !load;
        we_n   = !wr;
        addr   = AW'(a);
        bw_n   = bwn;
        step();
    endtask

    task automatic nop();
        ce1_n = 1'b1;
        cmd(1, 0, 0, '1);
        ce1_n = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog run did not finish act=0 exp=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        // R11: reset state
        cur_req = "R11";
        repeat (3) step();
        rst_n = 1'b1;
        chk(dq_oe === 1'b0, "dq_oe after reset", DW'(dq_oe), '0);
        step();
        chk(dq_oe === 1'b0, "dq_oe idle after reset", DW'(dq_oe), '0);

        // R1, R6: fill every word with full-lane writes
        cur_req = "R1";
        for (int i = 0; i < WORDS; i++) cmd(1, 1, i, '0);
        nop(); nop();

        // R5: read back every word
        cur_req = "R5";
        for (int i = 0; i < WORDS; i++) cmd(1, 0, i, '1);
        nop(); nop(); nop();

        // R3: linear bursts, five beats to cover the wrap
        cur_req = "R3";
        burst_ord = 1'b0;
        cmd(1, 1, 6, '0);
        for (int k = 0; k < 4; k++) cmd(0, 1, 0, '0);
        cmd(1, 0, 6, '1);
        for (int k = 0; k < 4; k++) cmd(0, 0, 0, '1);
        nop(); nop(); nop();

        // R4: interleaved bursts
        cur_req = "R4";
        burst_ord = 1'b1;
        cmd(1, 1, 13, '0);
        for (int k = 0; k < 3; k++) cmd(0, 1, 0, '0);
        burst_ord = 1'b0;          // sampled only at load
        cmd(1, 0, 14, '1);
        burst_ord = 1'b1;
        for (int k = 0; k < 3; k++) cmd(0, 0, 0, '1);
        cmd(1, 0, 13, '1);
        for (int k = 0; k < 3; k++) cmd(0, 0, 0, '1);
        burst_ord = 1'b0;
        nop(); nop(); nop();

        // R6: partial lane writes, then read back
        cur_req = "R6";
        cmd(1, 1, 2, 4'b1010);
        cmd(1, 1, 3, 4'b0111);
        nop(); nop(); nop();
        cmd(1, 0, 2, '1);
        cmd(1, 0, 3, '1);
        nop(); nop(); nop();

        // R7: read immediately after write to the same word (forwarding and merge)
        cur_req = "R7";
        cmd(1, 1, 9, 4'b0110);
        cmd(1, 0, 9, '1);
        cmd(1, 0, 9, '1);
        cmd(1, 1, 9, '0);
        cmd(1, 0, 9, '1);
        nop(); nop(); nop();

        // R12: alternate read and write on every cycle
        cur_req = "R12";
        for (int i = 0; i < 16; i++) cmd(1, (i % 2) == 0, (i / 4) + 4, '0);
        for (int i = 0; i < 16; i++) cmd(1, (i % 2) == 1, 5, (i % 3 == 0) ? 4'b0101 : 4'b0000);
        nop(); nop(); nop();

        // R8: each chip enable inactive in turn, then read the word
        cur_req = "R8";
        for (int j = 0; j < 3; j++) begin
            ce1_n = (j == 0); ce2 = (j != 1); ce3_n = (j == 2);
            cmd(1, 1, 1, '0);
            cmd(1, 0, 1, '1);
            ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
            nop(); nop();
            chk(dq_oe === 1'b0, "deselected read leaves bus off", DW'(dq_oe), '0);
            cmd(1, 0, 1, '1);
            nop(); nop();
        end

        // R9: suspend the clock in the middle of a read burst
        cur_req = "R9";
        cmd(1, 0, 8, '1);
        cmd(0, 0, 0, '1);
        cmd(0, 0, 0, '1);
        held = dq_out;
        clk_en_n = 1'b1;
        cmd(1, 1, 0, '0);
        cmd(0, 1, 3, '0);
        cmd(1, 1, 7, '0);
        chk(dq_out === held, "dq_out held while suspended", dq_out, held);
        clk_en_n = 1'b0;
        cmd(0, 0, 0, '1);
        nop(); nop(); nop();

        // R10: output enable gating
        cur_req = "R10";
        oe_n = 1'b1;
        cmd(1, 0, 4, '1);
        cmd(1, 0, 5, '1);
        nop();
        chk(dq_oe === 1'b0, "bus off with oe_n high", DW'(dq_oe), '0);
        oe_n = 1'b0;
        step();
        nop(); nop();

        // R2: random mixed traffic
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            ce1_n     = ($urandom % 10) == 0;
            ce2       = ($urandom % 10) != 0;
            ce3_n     = ($urandom % 10) == 0;
            clk_en_n  = ($urandom % 8) == 0;
            oe_n      = ($urandom % 8) == 0;
            burst_ord = $urandom % 2;
            cmd(($urandom % 3) == 0, $urandom % 2, $urandom % WORDS, LANES'($urandom));
        end
        clk_en_n = 1'b0; oe_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        nop(); nop(); nop();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule